// File: doc/BRIEF.md
# Three-Wire Serial Word Loader with Triple Buffering

This block receives control words for a frequency synthesiser over a three-wire serial link made of data, clock and enable lines. Bits enter a 24-bit shift register most significant bit first, one bit on each rising edge of the serial clock while enable is high. When enable falls, the two bits shifted in last form a destination code. That code sends the word to one of three storage buffers: two frequency words (F1 and F2) and one reference word. A fourth code updates only a small 4-bit auxiliary buffer. While a new word is being shifted in, the stored words keep driving the synthesiser unchanged.

The serial lines are sampled by the system clock through a synchroniser, so the serial clock may be much slower than the system clock and has no fixed phase relation to it. A select input chooses which frequency buffer drives the divider fields. The block decodes the divider count of that buffer according to the prescaler modulus held in the reference buffer. It also presents the reference fields.

Top module: `serial_loader`

## Requirements
- R1: While reset is asserted and after it is released, every buffer is zero, so all decoded outputs read zero.
- R2: On each synchronised rising edge of `ser_clk` while `ser_en` is high, the shift register moves left by one and takes `ser_dat` as its new bit 0. Serial clock edges while `ser_en` is low leave the shift register unchanged.
- R3: On a synchronised falling edge of `ser_en` with shift register bits [1:0] equal to 2'b00, bits [23:2] are copied into F1. No other buffer changes.
- R4: Destination code 2'b10 copies bits [23:2] into F2. No other buffer changes.
- R5: Destination code 2'b11 copies bits [17:2] into the reference buffer. In that buffer, bit 17 is the modulus select, bits [16:15] are the phase-detector mode, and bits [14:2] are the 13-bit reference ratio.
- R6: Destination code 2'b01 copies only bits [5:2] into the 4-bit auxiliary buffer (`a_aux`). F1, F2 and the reference buffer stay unchanged.
- R7: A frequency word holds, from shift register bit 23 down to bit 2: the 2-bit gain, the sense bit, and a 19-bit divider count. In the 16/17 modulus (modulus select 0), the M count is count[18:4] and the A count is count[3:0].
- R8: `f1_sel` high presents F1 and low presents F2. Rewriting the buffer that is not selected leaves the outputs unchanged.
- R9: With modulus select 1 (8/9), the M count is count[17:3] and the A count is {0, count[2:0]}.
- R10: Only the last bits shifted before enable falls matter. An 18-bit reference frame and a 24-bit frame whose last 18 bits are the same give the same reference contents.
- R11: No buffer changes except on an enable falling edge. The outputs keep their old values during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Serial enable; falling edge commits the word |
| f1_sel | input | 1 | 1 selects F1, 0 selects F2 |
| m_count | output | 15 | M count of the selected frequency word |
| a_count | output | 4 | A count of the selected frequency word |
| pd_gain | output | 2 | Phase-detector gain field |
| pd_sense | output | 1 | Phase-detector sense bit |
| r_ratio | output | 13 | Reference divider ratio |
| pd_mode | output | 2 | Phase-detector mode bits from the reference word |
| mod_half | output | 1 | Modulus select: 0 = 16/17, 1 = 8/9 |
| a_aux | output | 4 | Auxiliary A-count buffer |

## Verification
The assertions check on every cycle that:
- the buffers hold their values outside enable falling edges;
- a commit to F1 leaves F2 and the reference buffer untouched;
- a reference commit copies the correct shift register slice;
- each shift takes the synchronised data bit and nothing else moves the shift register.

Only the bench scenarios can show the following:
- MSB-first field placement;
- that serial clock edges with enable low are ignored;
- that a long frame keeps only its trailing bits;
- the modulus-dependent split of the count;
- that rewriting the inactive frequency word does not disturb the outputs.

// File: rtl/serial_loader_pkg.sv
package serial_loader_pkg;
  localparam int SR_W   = 24;
  localparam int CNT_W  = 19;
  localparam int M_W    = 15;
  localparam int A_W    = 4;
  localparam int R_W    = 13;
  localparam int GAIN_W = 2;
  localparam int MODE_W = 2;
  localparam int FW_W   = GAIN_W + 1 + CNT_W;   // 22
  localparam int RW_W   = 1 + MODE_W + R_W;     // 16
  localparam int CODE_W = 2;
  localparam int A_LO   = CODE_W;
  localparam int A_HI   = CODE_W + A_W - 1;

  typedef enum logic [CODE_W-1:0] {
    DST_F1    = 2'b00,
    DST_AONLY = 2'b01,
    DST_F2    = 2'b10,
    DST_REF   = 2'b11
  } dest_e;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic              sense;
    logic [CNT_W-1:0]  cnt;
  } freq_t;

  typedef struct packed {
    logic              half;
    logic [MODE_W-1:0] mode;
    logic [R_W-1:0]    ratio;
  } ref_t;
endpackage

// File: rtl/sl_sync_edge.sv
module sl_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = async_in;
      end else begin : g_next
        assign stg_d[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign lvl  = stg_q[STAGES-1];
  assign rise = stg_q[STAGES-1] & ~prev_q;
  assign fall = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter
  import serial_loader_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [SR_W-1:0] sr
);
  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[SR_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= sr_d;
  end

  assign sr = sr_q;
endmodule

// File: rtl/sl_bank.sv
module sl_bank
  import serial_loader_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [SR_W-1:0] sr,
  output logic [FW_W-1:0] f1_w,
  output logic [FW_W-1:0] f2_w,
  output logic [RW_W-1:0] ref_w,
  output logic [A_W-1:0]  aux_w
);
  dest_e code;
  assign code = dest_e'(sr[CODE_W-1:0]);

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_freq
      localparam dest_e MYC = (gi == 0) ? DST_F1 : DST_F2;
      logic            ld;
      logic [FW_W-1:0] q_r, d_c;
      assign ld  = commit && (code == MYC);
      assign d_c = ld ? sr[SR_W-1:CODE_W] : q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_r <= '0;
        else if (ld) q_r <= d_c;
      end
    end
  endgenerate

  assign f1_w = g_freq[0].q_r;
  assign f2_w = g_freq[1].q_r;

  logic            ref_ld, aux_ld;
  logic [RW_W-1:0] ref_q, ref_d;
  logic [A_W-1:0]  aux_q, aux_d;

  always_comb begin
    ref_ld = commit && (code == DST_REF);
    aux_ld = commit && (code == DST_AONLY);
    ref_d  = ref_ld ? sr[RW_W+CODE_W-1:CODE_W] : ref_q;
    aux_d  = aux_ld ? sr[A_HI:A_LO] : aux_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      aux_q <= '0;
    end else begin
      if (ref_ld) ref_q <= ref_d;
      if (aux_ld) aux_q <= aux_d;
    end
  end

  assign ref_w = ref_q;
  assign aux_w = aux_q;
endmodule

// File: rtl/sl_decode.sv
module sl_decode
  import serial_loader_pkg::*;
(
  input  logic [FW_W-1:0]   f1_w,
  input  logic [FW_W-1:0]   f2_w,
  input  logic [RW_W-1:0]   ref_w,
  input  logic              sel_f1,
  output logic [M_W-1:0]    m_count,
  output logic [A_W-1:0]    a_count,
  output logic [GAIN_W-1:0] pd_gain,
  output logic              pd_sense,
  output logic [R_W-1:0]    r_ratio,
  output logic [MODE_W-1:0] pd_mode,
  output logic              mod_half
);
  freq_t act;
  ref_t  rw;

  always_comb begin
    act      = freq_t'(sel_f1 ? f1_w : f2_w);
    rw       = ref_t'(ref_w);
    pd_gain  = act.gain;
    pd_sense = act.sense;
    r_ratio  = rw.ratio;
    pd_mode  = rw.mode;
    mod_half = rw.half;
    if (rw.half) begin
      m_count = act.cnt[CNT_W-2:A_W-1];
      a_count = {1'b0, act.cnt[A_W-2:0]};
    end else begin
      m_count = act.cnt[CNT_W-1:A_W];
      a_count = act.cnt[A_W-1:0];
    end
  end
endmodule

// File: rtl/serial_loader.sv
module serial_loader
  import serial_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en,
  input  logic              f1_sel,
  output logic [M_W-1:0]    m_count,
  output logic [A_W-1:0]    a_count,
  output logic [GAIN_W-1:0] pd_gain,
  output logic              pd_sense,
  output logic [R_W-1:0]    r_ratio,
  output logic [MODE_W-1:0] pd_mode,
  output logic              mod_half,
  output logic [A_W-1:0]    a_aux
);
  localparam int IDX_DAT = 0;
  localparam int IDX_CLK = 1;
  localparam int IDX_EN  = 2;

  logic [2:0]      s_lvl, s_rise, s_fall;
  logic            shift_en, commit, din;
  logic [SR_W-1:0] sr;
  logic [FW_W-1:0] f1_w, f2_w;
  logic [RW_W-1:0] ref_w;

  sl_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_en, ser_clk, ser_dat}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign din      = s_lvl[IDX_DAT];
  assign shift_en = s_rise[IDX_CLK] & s_lvl[IDX_EN];
  assign commit   = s_fall[IDX_EN];

  sl_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din), .sr(sr)
  );

  sl_bank u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sr(sr),
    .f1_w(f1_w), .f2_w(f2_w), .ref_w(ref_w), .aux_w(a_aux)
  );

  sl_decode u_dec (
    .f1_w(f1_w), .f2_w(f2_w), .ref_w(ref_w), .sel_f1(f1_sel),
    .m_count(m_count), .a_count(a_count), .pd_gain(pd_gain),
    .pd_sense(pd_sense), .r_ratio(r_ratio), .pd_mode(pd_mode),
    .mod_half(mod_half)
  );

  logic unused_edges;
  assign unused_edges = ^{s_rise[IDX_DAT], s_rise[IDX_EN], s_fall[IDX_DAT], s_fall[IDX_CLK], s_lvl[IDX_CLK]};
endmodule

// File: rtl/serial_loader_chk.sv
module serial_loader_chk
  import serial_loader_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            commit,
  input logic            shift_en,
  input logic            din,
  input logic [SR_W-1:0] sr,
  input logic [FW_W-1:0] f1_w,
  input logic [FW_W-1:0] f2_w,
  input logic [RW_W-1:0] ref_w
);
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(f1_w) && $stable(f2_w) && $stable(ref_w))); // R11
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr[0] == $past(din))); // R2
  AST_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr)); // R2
  AST_F1_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sr[1:0] == DST_F1) |=> ($stable(f2_w) && $stable(ref_w))); // R3
  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sr[1:0] == DST_REF) |=> (ref_w == $past(sr[RW_W+1:2]))); // R5
endmodule

bind serial_loader serial_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .shift_en(shift_en),
  .din(din), .sr(sr), .f1_w(f1_w), .f2_w(f2_w), .ref_w(ref_w)
);

// File: tb/serial_loader_test.sv
module serial_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_dat = 0, ser_en = 0, f1_sel = 1;
  logic [14:0] m_count; logic [3:0] a_count, a_aux;
  logic [1:0] pd_gain, pd_mode; logic pd_sense, mod_half;
  logic [12:0] r_ratio;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  serial_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en(ser_en), .f1_sel(f1_sel), .m_count(m_count), .a_count(a_count),
    .pd_gain(pd_gain), .pd_sense(pd_sense), .r_ratio(r_ratio),
    .pd_mode(pd_mode), .mod_half(mod_half), .a_aux(a_aux)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: input history queue, word values as integers
  logic [2:0]  hist[$];   // {en, clk, dat}
  logic [23:0] m_sr;
  logic [21:0] m_f1, m_f2;
  logic [15:0] m_ref;
  logic [3:0]  m_aux;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b000, 3'b000, 3'b000};
      m_sr = 0; m_f1 = 0; m_f2 = 0; m_ref = 0; m_aux = 0;
    end else begin
      logic [2:0] d2, d3;
      d2 = hist[hist.size()-2];
      d3 = hist[hist.size()-3];
      if (d3[2] && !d2[2]) begin
        case (m_sr[1:0])
          2'b00: m_f1 = m_sr[23:2];
          2'b10: m_f2 = m_sr[23:2];
          2'b11: m_ref = m_sr[17:2];
          default: m_aux = m_sr[5:2];
        endcase
      end
      if (d2[1] && !d3[1] && d2[2]) m_sr = {m_sr[22:0], d2[0]};
      hist.push_back({ser_en, ser_clk, ser_dat});
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [18:0] exp_ma(logic [21:0] w, logic half);
    logic [18:0] c = w[18:0];
    if (half) return {c[17:3], 1'b0, c[2:0]};
    return {c[18:4], c[3:0]};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [21:0] act;
      logic [18:0] ma;
      act = f1_sel ? m_f1 : m_f2;
      ma  = exp_ma(act, m_ref[15]);
      chk("R7 per-cycle m/a", {13'd0, m_count, a_count}, {13'd0, ma});
      chk("R8 per-cycle gain/sense", {29'd0, pd_gain, pd_sense}, {29'd0, act[21:19]});
      chk("R5 per-cycle ref", {16'd0, mod_half, pd_mode, r_ratio}, {16'd0, m_ref});
      chk("R6 per-cycle aux", {28'd0, a_aux}, {28'd0, m_aux});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic begin_frame(); ser_en = 1; tick(3); endtask
  task automatic end_frame();   ser_en = 0; tick(6); endtask
  task automatic shift_bits(logic [23:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = w[i]; tick(3);
      ser_clk = 1;    tick(3);
      ser_clk = 0;    tick(2);
    end
  endtask
  task automatic send(logic [23:0] w, int n);
    begin_frame(); shift_bits(w, n); end_frame();
  endtask

  task automatic expect_f(string tag, logic [14:0] m, logic [3:0] a, logic [1:0] g, logic s);
    chk(tag, {12'd0, m, a, g, s}, {12'd0, m_count, a_count, pd_gain, pd_sense});
  endtask

  localparam logic [23:0] F1W = {2'b10, 1'b1, 15'h1234, 4'h9, 2'b00};
  localparam logic [23:0] F2W = {2'b01, 1'b0, 15'h0456, 4'hC, 2'b10};
  localparam logic [23:0] F1B = {2'b11, 1'b0, 15'h7001, 4'h3, 2'b00};

  initial begin
    tick(4);
    expect_f("R1 reset freq fields", 0, 0, 0, 0);
    chk("R1 reset ref/aux", {r_ratio, pd_mode, mod_half, a_aux}, 0);
    rst_n = 1; tick(2);
    expect_f("R1 after release", 0, 0, 0, 0);

    send(F1W, 24);
    expect_f("R3 R2 R7 F1 load", 15'h1234, 4'h9, 2'b10, 1'b1);

    send(F2W, 24);
    expect_f("R8 F2 write while F1 active", 15'h1234, 4'h9, 2'b10, 1'b1);
    f1_sel = 0; tick(1);
    expect_f("R4 F2 selected", 15'h0456, 4'hC, 2'b01, 1'b0);
    f1_sel = 1; tick(1);

    send({6'd0, 1'b0, 2'b01, 13'h0ABC, 2'b11}, 18);
    chk("R5 ref load", {r_ratio, pd_mode, mod_half}, {13'h0ABC, 2'b01, 1'b0});

    send({18'h3FFFF, 4'h5, 2'b01}, 24);
    chk("R6 aux load", a_aux, 4'h5);
    expect_f("R6 F1 untouched", 15'h1234, 4'h9, 2'b10, 1'b1);
    chk("R6 ref untouched", {r_ratio, pd_mode, mod_half}, {13'h0ABC, 2'b01, 1'b0});

    send({6'd0, 1'b1, 2'b10, 13'h0123, 2'b11}, 18);
    begin
      logic [18:0] c = F1W[20:2];
      expect_f("R9 8/9 decode", c[17:3], {1'b0, c[2:0]}, 2'b10, 1'b1);
    end

    send({6'h3F, 1'b0, 2'b11, 13'h1F0F, 2'b11}, 24);
    chk("R10 long frame", {r_ratio, pd_mode, mod_half}, {13'h1F0F, 2'b11, 1'b0});

    ser_dat = 1;
    for (int k = 0; k < 6; k++) begin
      ser_clk = 1; tick(3); ser_clk = 0; tick(3);
    end
    ser_dat = 0;
    send(24'd0, 0);
    chk("R2 clocks with enable low ignored", {r_ratio, pd_mode, mod_half}, {13'h1F0F, 2'b11, 1'b0});

    begin_frame();
    shift_bits(F1B >> 12, 12);
    expect_f("R11 mid-frame hold", 15'h1234, 4'h9, 2'b10, 1'b1);
    shift_bits(F1B, 12);
    expect_f("R11 before enable falls", 15'h1234, 4'h9, 2'b10, 1'b1);
    end_frame();
    expect_f("R3 R7 F1 rewrite", 15'h7001, 4'h3, 2'b11, 1'b0);
    f1_sel = 0; tick(1);
    expect_f("R8 F2 still stored", 15'h0456, 4'hC, 2'b01, 1'b0);

    tick(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule